// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block picks instructions to issue inside one multiprocessor. It keeps a table of up to 48 resident warp slots. Each slot has a valid bit and a four-bit mask of stall reasons. A slot is ready when it is valid and its stall mask is zero. Two scheduler lanes work side by side. Lane 0 owns the even slots and lane 1 owns the odd slots. Each lane offers at most one warp per cycle to its own issue port, so two warps can leave in the same cycle. The two warps need not come from the same thread block.

Each lane picks round-robin. The search starts at the owned slot after the warp that lane last issued. Each port has a resource-available input. If that input is low, the port does not issue and the execution side never waits. The lane remembers the refused warp and offers it again, ahead of every other warp, until it issues. The block also counts the cycles in which no slot anywhere was ready.

Top module: `warp_sched_top`

## Requirements
- R1: After reset no slot is valid, every stall mask is clear, both issue valids are low and the idle counter reads 0.
- R2: A pulse on `alloc_vld` with `alloc_idx` makes that slot valid with a clear stall mask from the next cycle. A pulse on `free_vld` with `free_idx` makes that slot invalid from the next cycle. If both name the same slot in one cycle, the free wins.
- R3: Stall codes select one mask bit each: 0 barrier, 1 memory, 2 texture, 3 data dependency. `stall_set_vld` sets the coded bit of `stall_set_idx` and `stall_clr_vld` clears the coded bit of `stall_clr_idx`. A slot is never issued while any of its mask bits is set. Clearing one reason leaves the others in force.
- R4: Port 0 only ever issues even slot indices and port 1 only odd ones. A port issues whenever any slot it owns is ready and its resource input is high.
- R5: Both ports can issue in the same cycle.
- R6: Among its ready slots, a lane issues the first one found in cyclic slot order after the slot it last issued. After reset the search starts from the lowest owned slot.
- R7: Issue valid and index follow the current state and `res_avail` in the same cycle, and a port never issues while its `res_avail` bit is low. A warp offered but refused is held by its lane. While the held warp is ready it is offered before any other. The hold ends when that warp issues or when its slot is no longer valid.
- R8: `idle_cnt` rises by one in every cycle in which no slot is ready, and it saturates at its maximum value.
- R9: When a stall set and a stall clear hit the same bit of the same slot in one cycle, the set wins. An allocation clears the whole mask of its slot even if a stall set targets that slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Allocate a warp slot |
| alloc_idx | input | 6 | Slot to allocate |
| free_vld | input | 1 | Release a warp slot |
| free_idx | input | 6 | Slot to release |
| stall_set_vld | input | 1 | Add a stall reason |
| stall_set_idx | input | 6 | Slot receiving the reason |
| stall_set_rsn | input | 2 | Reason code to set |
| stall_clr_vld | input | 1 | Remove a stall reason |
| stall_clr_idx | input | 6 | Slot losing the reason |
| stall_clr_rsn | input | 2 | Reason code to clear |
| res_avail | input | 2 | Execution resource free, one bit per port |
| iss_vld | output | 2 | Issue valid, one bit per port |
| iss_idx0 | output | 6 | Slot issued on port 0 |
| iss_idx1 | output | 6 | Slot issued on port 1 |
| idle_cnt | output | 16 | Saturating count of cycles with no ready slot |

## Verification
The bench targets the replay hold. If the hold is lost, the refused warp is overtaken by its round-robin neighbour once the resource returns. If the hold is kept after the slot is freed, the lane stalls or issues a dead slot. Pointer wrap across the top owned slot is also checked: an off-by-one there skips a warp or issues one twice in a row. Same-cycle collisions of set against clear, alloc against set, and alloc against free are driven on purpose, because a wrong priority leaves a warp blocked or issues a stalled one. The idle counter is run past its limit, since a missing saturation would wrap it to zero.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int RSN_W   = 2;
  localparam int NUM_RSN = 1 << RSN_W;

  typedef enum logic [RSN_W-1:0] {
    RSN_BARRIER = 2'd0,
    RSN_MEMORY  = 2'd1,
    RSN_TEXTURE = 2'd2,
    RSN_DEPEND  = 2'd3
  } stall_rsn_e;
endpackage

// File: rtl/warp_table.sv
module warp_table
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 48,
  localparam int IDX_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_vld,
  input  logic [IDX_W-1:0]     alloc_idx,
  input  logic                 free_vld,
  input  logic [IDX_W-1:0]     free_idx,
  input  logic                 set_vld,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic [RSN_W-1:0]     set_rsn,
  input  logic                 clr_vld,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic [RSN_W-1:0]     clr_rsn,
  output logic [NUM_WARPS-1:0] slot_vld,
  output logic [NUM_WARPS-1:0] slot_rdy
);
  logic [NUM_WARPS-1:0] vld_q, vld_d;
  logic [NUM_RSN-1:0]   mask_q [NUM_WARPS];
  logic [NUM_RSN-1:0]   mask_d [NUM_WARPS];
  logic [NUM_RSN-1:0]   set_bit, clr_bit;

  assign set_bit = NUM_RSN'(1) << set_rsn;
  assign clr_bit = NUM_RSN'(1) << clr_rsn;

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      vld_d[w]  = vld_q[w];
      mask_d[w] = mask_q[w];
      if (clr_vld && clr_idx == IDX_W'(w)) mask_d[w] = mask_d[w] & ~clr_bit;
      if (set_vld && set_idx == IDX_W'(w)) mask_d[w] = mask_d[w] | set_bit;
      if (alloc_vld && alloc_idx == IDX_W'(w)) begin
        vld_d[w]  = 1'b1;
        mask_d[w] = '0;
      end
      if (free_vld && free_idx == IDX_W'(w)) vld_d[w] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int w = 0; w < NUM_WARPS; w++) mask_q[w] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int w = 0; w < NUM_WARPS; w++) mask_q[w] <= mask_d[w];
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) slot_rdy[w] = vld_q[w] && (mask_q[w] == '0);
  end
  assign slot_vld = vld_q;
endmodule

// File: rtl/warp_picker.sv
module warp_picker #(
  parameter int SLOTS = 24,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  own_vld,
  input  logic [SLOTS-1:0]  own_rdy,
  input  logic              res_ok,
  output logic              issue,
  output logic [SLOT_W-1:0] issue_slot
);
  logic [SLOT_W-1:0] last_q, last_d;
  logic              hold_q, hold_d;
  logic [SLOT_W-1:0] hslot_q, hslot_d;
  logic              cand_ok;
  logic [SLOT_W-1:0] cand;
  logic              use_hold;

  assign use_hold = hold_q && own_rdy[hslot_q];

  always_comb begin
    cand_ok = 1'b0;
    cand    = '0;
    if (use_hold) begin
      cand_ok = 1'b1;
      cand    = hslot_q;
    end else begin
      for (int j = 1; j <= SLOTS; j++) begin
        if (!cand_ok && own_rdy[(int'(last_q) + j) % SLOTS]) begin
          cand_ok = 1'b1;
          cand    = SLOT_W'((int'(last_q) + j) % SLOTS);
        end
      end
    end
  end

  assign issue      = cand_ok && res_ok;
  assign issue_slot = cand;

  always_comb begin
    last_d  = last_q;
    hold_d  = hold_q;
    hslot_d = hslot_q;
    if (hold_q && !own_vld[hslot_q]) hold_d = 1'b0;
    if (issue) begin
      last_d = cand;
      if (use_hold) hold_d = 1'b0;
    end else if (cand_ok) begin
      hold_d  = 1'b1;
      hslot_d = cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= SLOT_W'(SLOTS - 1);
      hold_q  <= 1'b0;
      hslot_q <= '0;
    end else begin
      last_q  <= last_d;
      hold_q  <= hold_d;
      hslot_q <= hslot_d;
    end
  end
endmodule

// File: rtl/idle_counter.sv
module idle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             none_rdy,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = none_rdy && (cnt_q != {CNT_W{1'b1}});
  assign cnt_d  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
  assign count = cnt_q;
endmodule

// File: rtl/warp_sched_top.sv
module warp_sched_top
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 48,
  parameter int CNT_W     = 16,
  localparam int HALF   = NUM_WARPS / 2,
  localparam int SLOT_W = $clog2(HALF),
  localparam int IDX_W  = SLOT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_vld,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic               free_vld,
  input  logic [IDX_W-1:0]   free_idx,
  input  logic               stall_set_vld,
  input  logic [IDX_W-1:0]   stall_set_idx,
  input  logic [RSN_W-1:0]   stall_set_rsn,
  input  logic               stall_clr_vld,
  input  logic [IDX_W-1:0]   stall_clr_idx,
  input  logic [RSN_W-1:0]   stall_clr_rsn,
  input  logic [1:0]         res_avail,
  output logic [1:0]         iss_vld,
  output logic [IDX_W-1:0]   iss_idx0,
  output logic [IDX_W-1:0]   iss_idx1,
  output logic [CNT_W-1:0]   idle_cnt
);
  logic [NUM_WARPS-1:0] warp_vld, warp_rdy;
  logic [HALF-1:0]      own_vld [2];
  logic [HALF-1:0]      own_rdy [2];
  logic [SLOT_W-1:0]    pick_slot [2];

  warp_table #(.NUM_WARPS(NUM_WARPS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_idx(alloc_idx[$clog2(NUM_WARPS)-1:0]),
    .free_vld(free_vld), .free_idx(free_idx[$clog2(NUM_WARPS)-1:0]),
    .set_vld(stall_set_vld), .set_idx(stall_set_idx[$clog2(NUM_WARPS)-1:0]),
    .set_rsn(stall_set_rsn),
    .clr_vld(stall_clr_vld), .clr_idx(stall_clr_idx[$clog2(NUM_WARPS)-1:0]),
    .clr_rsn(stall_clr_rsn),
    .slot_vld(warp_vld), .slot_rdy(warp_rdy)
  );

  for (genvar k = 0; k < 2; k++) begin : g_lane
    for (genvar s = 0; s < HALF; s++) begin : g_slot
      assign own_vld[k][s] = warp_vld[2*s + k];
      assign own_rdy[k][s] = warp_rdy[2*s + k];
    end
    warp_picker #(.SLOTS(HALF)) u_pick (
      .clk(clk), .rst_n(rst_n),
      .own_vld(own_vld[k]), .own_rdy(own_rdy[k]),
      .res_ok(res_avail[k]),
      .issue(iss_vld[k]), .issue_slot(pick_slot[k])
    );
  end

  assign iss_idx0 = {pick_slot[0], 1'b0};
  assign iss_idx1 = {pick_slot[1], 1'b1};

  idle_counter #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .none_rdy(warp_rdy == '0),
    .count(idle_cnt)
  );
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS = 48,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           res_avail,
  input logic [1:0]           iss_vld,
  input logic [IDX_W-1:0]     iss_idx0,
  input logic [IDX_W-1:0]     iss_idx1,
  input logic [CNT_W-1:0]     idle_cnt,
  input logic [NUM_WARPS-1:0] warp_rdy
);
  // R4
  port0_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[0] |-> !iss_idx0[0]);
  // R4
  port1_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> iss_idx1[0]);
  // R7
  res_gate0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_avail[0] |-> !iss_vld[0]);
  // R7
  res_gate1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_avail[1] |-> !iss_vld[1]);
  // R3
  rdy_only0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[0] |-> warp_rdy[iss_idx0]);
  // R3
  rdy_only1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> warp_rdy[iss_idx1]);
  // R8
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_rdy == '0 && idle_cnt != {CNT_W{1'b1}}) |=> idle_cnt == $past(idle_cnt) + CNT_W'(1));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_rdy != '0) |=> $stable(idle_cnt));
endmodule

bind warp_sched_top warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_avail(res_avail), .iss_vld(iss_vld),
  .iss_idx0(iss_idx0), .iss_idx1(iss_idx1), .idle_cnt(idle_cnt), .warp_rdy(warp_rdy)
);

// File: tb/warp_sched_top_bench.sv
module warp_sched_top_bench;
  localparam int NW = 48;
  localparam int H  = NW / 2;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk;
  logic rst_n;
  logic alloc_vld, free_vld, set_vld, clr_vld;
  logic [5:0] alloc_idx, free_idx, set_idx, clr_idx;
  logic [1:0] set_rsn, clr_rsn, res_avail, iss_vld;
  logic [5:0] iss_idx0, iss_idx1;
  logic [CW-1:0] idle_cnt;

  warp_sched_top #(.NUM_WARPS(NW), .CNT_W(CW)) u_warp_sched_top (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
    .free_vld(free_vld), .free_idx(free_idx),
    .stall_set_vld(set_vld), .stall_set_idx(set_idx), .stall_set_rsn(set_rsn),
    .stall_clr_vld(clr_vld), .stall_clr_idx(clr_idx), .stall_clr_rsn(clr_rsn),
    .res_avail(res_avail), .iss_vld(iss_vld),
    .iss_idx0(iss_idx0), .iss_idx1(iss_idx1), .idle_cnt(idle_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nrun = 0;
  int nfail = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  bit       m_vld [NW];
  bit [3:0] m_mask [NW];
  int       m_last [2];
  bit       m_hold [2];
  int       m_hslot [2];
  int       m_idle;

  task automatic chk(string t, string what, int act, int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  function automatic bit rdy(int w);
    return m_vld[w] && m_mask[w] == 4'd0;
  endfunction

  task automatic clear_in();
    alloc_vld = 0; free_vld = 0; set_vld = 0; clr_vld = 0;
    alloc_idx = 0; free_idx = 0; set_idx = 0; clr_idx = 0;
    set_rsn = 0; clr_rsn = 0;
  endtask

  // inputs are already driven after a negedge; check, advance model, move to next negedge
  task automatic step();
    bit any;
    bit cok [2];
    int cs [2];
    bit useh [2];
    bit iss [2];
    #5;
    any = 0;
    for (int w = 0; w < NW; w++) if (rdy(w)) any = 1;
    for (int k = 0; k < 2; k++) begin
      cok[k] = 0; cs[k] = 0;
      useh[k] = m_hold[k] && rdy(2*m_hslot[k] + k);
      if (useh[k]) begin
        cok[k] = 1; cs[k] = m_hslot[k];
      end else begin
        for (int j = 1; j <= H; j++) begin
          int s = (m_last[k] + j) % H;
          if (!cok[k] && rdy(2*s + k)) begin cok[k] = 1; cs[k] = s; end
        end
      end
      iss[k] = cok[k] && res_avail[k];
      chk(tag, $sformatf("port%0d valid", k), int'(iss_vld[k]), int'(iss[k]));
      if (iss[k])
        chk(tag, $sformatf("port%0d index", k), k == 0 ? int'(iss_idx0) : int'(iss_idx1), 2*cs[k] + k);
    end
    chk(tag, "idle count", int'(idle_cnt), m_idle);
    // next state of the pickers
    for (int k = 0; k < 2; k++) begin
      bit drop = m_hold[k] && !m_vld[2*m_hslot[k] + k];
      if (drop) m_hold[k] = 0;
      if (iss[k]) begin
        m_last[k] = cs[k];
        if (useh[k]) m_hold[k] = 0;
      end else if (cok[k]) begin
        m_hold[k] = 1; m_hslot[k] = cs[k];
      end
    end
    if (!any && m_idle < CMAX) m_idle++;
    // next state of the table
    if (clr_vld) m_mask[clr_idx] &= ~(4'd1 << clr_rsn);
    if (set_vld) m_mask[set_idx] |= (4'd1 << set_rsn);
    if (alloc_vld) begin m_vld[alloc_idx] = 1; m_mask[alloc_idx] = 0; end
    if (free_vld) m_vld[free_idx] = 0;
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_alloc(int w);
    alloc_vld = 1; alloc_idx = 6'(w); step();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; res_avail = 2'b11; clear_in();
    for (int w = 0; w < NW; w++) begin m_vld[w] = 0; m_mask[w] = 0; end
    for (int k = 0; k < 2; k++) begin m_last[k] = H - 1; m_hold[k] = 0; m_hslot[k] = 0; end
    m_idle = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "iss_vld in reset", int'(iss_vld), 0);
    chk("R1", "idle in reset", int'(idle_cnt), 0);
    rst_n = 1;
    tag = "R1"; step();

    // R2: allocate a few slots, then free one
    tag = "R2";
    for (int w = 0; w < 6; w++) do_alloc(w);
    repeat (4) step();
    free_vld = 1; free_idx = 6'd2; step();
    alloc_vld = 1; alloc_idx = 6'd4; free_vld = 1; free_idx = 6'd4; step();
    repeat (4) step();

    // R3: stall reasons block issue; partial clear keeps the block
    tag = "R3";
    set_vld = 1; set_idx = 6'd0; set_rsn = 2'd1; step();
    set_vld = 1; set_idx = 6'd0; set_rsn = 2'd3; step();
    clr_vld = 1; clr_idx = 6'd0; clr_rsn = 2'd1; step();
    repeat (4) step();
    clr_vld = 1; clr_idx = 6'd0; clr_rsn = 2'd3; step();
    set_vld = 1; set_idx = 6'd1; set_rsn = 2'd0; step();
    set_vld = 1; set_idx = 6'd3; set_rsn = 2'd2; step();
    repeat (3) step();
    clr_vld = 1; clr_idx = 6'd1; clr_rsn = 2'd0; step();
    clr_vld = 1; clr_idx = 6'd3; clr_rsn = 2'd2; step();

    // R5 and R6: fill the table, dual issue with wrap of the pointers
    tag = "R6";
    for (int w = 6; w < NW; w++) do_alloc(w);
    tag = "R5";
    repeat (60) step();

    // R7: refused dispatch holds the warp until it issues
    tag = "R7";
    res_avail = 2'b10; repeat (3) step();
    set_vld = 1; set_idx = 6'd1; set_rsn = 2'd2; step();
    res_avail = 2'b11; repeat (3) step();
    res_avail = 2'b01; step();
    set_vld = 1; set_idx = iss_idx1; set_rsn = 2'd1; res_avail = 2'b01; step();
    res_avail = 2'b11; repeat (3) step();
    res_avail = 2'b00; step();
    res_avail = 2'b10; free_vld = 1; free_idx = 6'(2 * ((m_last[0] + 1) % H)); step();
    res_avail = 2'b11; repeat (4) step();

    // R9: collision priorities
    tag = "R9";
    set_vld = 1; set_idx = 6'd10; set_rsn = 2'd2;
    clr_vld = 1; clr_idx = 6'd10; clr_rsn = 2'd2; step();
    repeat (24) step();
    alloc_vld = 1; alloc_idx = 6'd10; set_vld = 1; set_idx = 6'd10; set_rsn = 2'd0; step();
    repeat (24) step();

    // R8: empty table, idle count runs to saturation
    tag = "R8";
    for (int w = 0; w < NW; w++) begin free_vld = 1; free_idx = 6'(w); step(); end
    repeat (CMAX + 10) step();
    do_alloc(7);
    repeat (3) step();

    // R4: random traffic against the model
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      alloc_vld = ($urandom_range(0, 3) == 0); alloc_idx = 6'($urandom_range(0, NW - 1));
      free_vld  = ($urandom_range(0, 5) == 0); free_idx  = 6'($urandom_range(0, NW - 1));
      set_vld   = ($urandom_range(0, 2) == 0); set_idx   = 6'($urandom_range(0, NW - 1));
      set_rsn   = 2'($urandom_range(0, 3));
      clr_vld   = ($urandom_range(0, 1) == 0); clr_idx   = 6'($urandom_range(0, NW - 1));
      clr_rsn   = 2'($urandom_range(0, 3));
      res_avail = 2'($urandom_range(0, 3));
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule